// File: doc/BRIEF.md
# UART Interrupt Identification Unit

This unit gathers the interrupt causes of a 16550-compatible serial port and turns them into a single active-high interrupt request and the byte returned by a read of the identification register. It takes five causes: a receive line error, received data ready (or the receive trigger reached), a receive character timeout, an empty transmit holding register, and a change on a modem input. Each cause has its own enable. When several causes are pending, the one with the highest fixed priority is reported.

The bus decoder supplies one-cycle read strobes for the identification, line-status and modem-status registers. The unit applies the side effects of those reads. Reading the identification register while the transmit-empty code is shown discharges that cause. A line-status read discharges the latched line-error cause. A modem-status read discharges the latched modem cause. The two upper bits of the identification byte show whether the FIFOs are enabled. The receive FIFO, the timeout counter and the status registers themselves are outside this unit. It sees only their condition signals.

Top module: `uart_irq_ident`

## Requirements
- R1: After reset, and whenever no enabled cause is pending, bit 0 of `ident_o` is 1 and `irq_o` is 0. Whenever a cause is reported, bit 0 is 0 and `irq_o` is 1. `irq_o` is always the inverse of bit 0.
- R2: Bits 7:6 of `ident_o` are `11` while `fifo_on` is 1 and `00` while it is 0. Bits 5:4 are always 0.
- R3: A one-cycle pulse on any bit of `line_err` latches a line-error cause from the next cycle onward. The bits are bit0 overrun, bit1 parity, bit2 framing and bit3 break. While `ien_line` is 1, this cause is reported as code 4'h6 in bits 3:0.
- R4: A `rd_line` strobe clears the latched line-error cause from the next cycle onward. If a `line_err` pulse arrives in the same cycle as the strobe, the cause stays latched.
- R5: While `rx_avail` and `ien_rx` are both 1, code 4'h4 is reported, in the same cycle.
- R6: While `rx_timeout`, `fifo_on` and `ien_rx` are 1 and `rx_avail` is 0, code 4'hC is reported. When `fifo_on` is 0, `rx_timeout` has no effect. When `rx_avail` is 1, code 4'h4 is reported instead.
- R7: A 0-to-1 change of `thr_empty` arms the transmit-empty cause from the next cycle onward. While `ien_tx` is 1, this cause is reported as code 4'h2.
- R8: A `rd_ident` strobe in a cycle where code 4'h2 is shown disarms the transmit-empty cause from the next cycle onward. A `rd_ident` strobe while any other code is shown changes nothing.
- R9: A 0-to-1 change of `ien_tx` while `thr_empty` is 1 arms the transmit-empty cause from the next cycle onward. `thr_empty` at 0 disarms it from the next cycle onward.
- R10: A one-cycle pulse on any bit of `modem_delta` latches a modem cause. The bits are bit0 CTS change, bit1 DSR change, bit2 ring change and bit3 carrier change. While `ien_modem` is 1, this cause is reported as code 4'h0. A `rd_modem` strobe clears it from the next cycle onward, unless a new pulse arrives in that same cycle.
- R11: The priority from highest to lowest is line error, then receive data or timeout, then transmit empty, then modem change.
- R12: Clearing an enable hides its cause without discarding it. A latched or armed cause appears as soon as its enable is set again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fifo_on | input | 1 | FIFOs enabled |
| ien_line | input | 1 | Enable for the line-error cause |
| ien_rx | input | 1 | Enable for the receive data and timeout causes |
| ien_tx | input | 1 | Enable for the transmit-empty cause |
| ien_modem | input | 1 | Enable for the modem-change cause |
| line_err | input | 4 | Line-error event pulses: overrun, parity, framing, break |
| rx_avail | input | 1 | Receive data ready or trigger level reached (level) |
| rx_timeout | input | 1 | Character timeout condition (level) |
| thr_empty | input | 1 | Transmit holding register or FIFO empty (level) |
| modem_delta | input | 4 | Modem change pulses: CTS, DSR, ring, carrier |
| rd_ident | input | 1 | Read strobe of the identification register |
| rd_line | input | 1 | Read strobe of the line-status register |
| rd_modem | input | 1 | Read strobe of the modem-status register |
| irq_o | output | 1 | Interrupt request, active high |
| ident_o | output | 8 | Identification byte |

## Verification
Two side effects are hard to reach from the ports: a cause that is re-armed in the same cycle it is read, and the transmit-empty cause re-arming when its enable is set again while the holding register stays empty. To reach them, the stimulus toggles `ien_tx` with `thr_empty` held high. It also fires event pulses together with the read strobes that would otherwise clear them. Priority is checked by stacking causes one on top of another. Each cause is then removed in turn, and the bench confirms that the next lower code appears in the following cycle.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

  typedef enum logic [3:0] {
    ID_MODEM = 4'h0,
    ID_NONE  = 4'h1,
    ID_THRE  = 4'h2,
    ID_RXD   = 4'h4,
    ID_LINE  = 4'h6,
    ID_TMO   = 4'hC
  } iid_e;

  // Fixed-priority pick among the enabled, active causes.
  function automatic iid_e pick_id(input logic line, input logic rxd,
                                   input logic tmo, input logic thre,
                                   input logic modem);
    if (line)       return ID_LINE;
    else if (rxd)   return ID_RXD;
    else if (tmo)   return ID_TMO;
    else if (thre)  return ID_THRE;
    else if (modem) return ID_MODEM;
    else            return ID_NONE;
  endfunction

  // Assemble the identification byte from the FIFO flag and the code.
  function automatic logic [7:0] ident_byte(input logic fifo_on, input iid_e id);
    return {{2{fifo_on}}, 2'b00, id};
  endfunction

endpackage

// File: rtl/uart_irq_sticky.sv
module uart_irq_sticky #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] evt,
  input  logic         clr,
  output logic         pend
);

  logic any_evt;
  assign any_evt = |evt;

  // A new event wins over a clearing read in the same cycle.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pend <= 1'b0;
    else if (any_evt) pend <= 1'b1;
    else if (clr)     pend <= 1'b0;
  end

  // R3 / R10: any event latches the cause
  p_sticky_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt) |=> pend);
  // R4 / R10: a read with no fresh event clears the cause
  p_sticky_clr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !(|evt)) |=> !pend);
  // R12: the cause is retained until a read
  p_sticky_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && !clr) |=> pend);

endmodule

// File: rtl/uart_irq_txarm.sv
module uart_irq_txarm (
  input  logic clk,
  input  logic rst_n,
  input  logic thr_empty,
  input  logic ien_tx,
  input  logic ack,
  output logic pend
);

  logic thr_q, en_q;
  logic thr_rise, en_rise, arm, disarm;

  assign thr_rise = thr_empty && !thr_q;
  assign en_rise  = ien_tx && !en_q && thr_empty;
  assign arm      = thr_rise || en_rise;
  assign disarm   = !thr_empty || ack;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      thr_q <= 1'b0;
      en_q  <= 1'b0;
      pend  <= 1'b0;
    end else begin
      thr_q <= thr_empty;
      en_q  <= ien_tx;
      if (arm)         pend <= 1'b1;
      else if (disarm) pend <= 1'b0;
    end
  end

  // R7: holding register becoming empty arms the cause
  p_tx_arm_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (thr_empty && !thr_q) |=> pend);
  // R8: acknowledged by an identification read
  p_tx_ack_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !arm) |=> !pend);
  // R9: a loaded holding register disarms the cause
  p_tx_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !thr_empty |=> !pend);

endmodule

// File: rtl/uart_irq_prio.sv
module uart_irq_prio
  import uart_irq_pkg::*;
(
  input  logic       act_line,
  input  logic       act_rxd,
  input  logic       act_tmo,
  input  logic       act_thre,
  input  logic       act_modem,
  input  logic       fifo_on,
  output iid_e       iid,
  output logic [7:0] ident
);

  assign iid   = pick_id(act_line, act_rxd, act_tmo, act_thre, act_modem);
  assign ident = ident_byte(fifo_on, iid);

endmodule

// File: rtl/uart_irq_ident.sv
module uart_irq_ident
  import uart_irq_pkg::*;
#(
  parameter int ERR_W   = 4,
  parameter int DELTA_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               fifo_on,
  input  logic               ien_line,
  input  logic               ien_rx,
  input  logic               ien_tx,
  input  logic               ien_modem,
  input  logic [ERR_W-1:0]   line_err,
  input  logic               rx_avail,
  input  logic               rx_timeout,
  input  logic               thr_empty,
  input  logic [DELTA_W-1:0] modem_delta,
  input  logic               rd_ident,
  input  logic               rd_line,
  input  logic               rd_modem,
  output logic               irq_o,
  output logic [7:0]         ident_o
);

  logic line_pend, modem_pend, tx_pend;
  logic act_line, act_rxd, act_tmo, act_thre, act_modem;
  logic tx_ack;
  iid_e iid;

  uart_irq_sticky #(.W(ERR_W)) u_line (
    .clk(clk), .rst_n(rst_n), .evt(line_err), .clr(rd_line), .pend(line_pend));

  uart_irq_sticky #(.W(DELTA_W)) u_modem (
    .clk(clk), .rst_n(rst_n), .evt(modem_delta), .clr(rd_modem), .pend(modem_pend));

  uart_irq_txarm u_tx (
    .clk(clk), .rst_n(rst_n), .thr_empty(thr_empty), .ien_tx(ien_tx),
    .ack(tx_ack), .pend(tx_pend));

  // Enable gating: causes are kept even while hidden.
  assign act_line  = line_pend && ien_line;
  assign act_rxd   = rx_avail && ien_rx;
  assign act_tmo   = rx_timeout && fifo_on && ien_rx;
  assign act_thre  = tx_pend && ien_tx;
  assign act_modem = modem_pend && ien_modem;

  uart_irq_prio u_prio (
    .act_line(act_line), .act_rxd(act_rxd), .act_tmo(act_tmo),
    .act_thre(act_thre), .act_modem(act_modem), .fifo_on(fifo_on),
    .iid(iid), .ident(ident_o));

  assign tx_ack = rd_ident && (iid == ID_THRE);
  assign irq_o  = ~ident_o[0];

  // R11: a line error outranks every other cause
  p_line_first_r11: assert property (@(posedge clk) disable iff (!rst_n)
    act_line |-> (ident_o[3:0] == 4'h6));
  // R11: transmit empty is never shown over receive data
  p_rx_over_tx_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (act_rxd && !act_line) |-> (ident_o[3:0] == 4'h4));
  // R1: no active cause means no request
  p_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !(act_line || act_rxd || act_tmo || act_thre || act_modem) |-> !irq_o);
  // R2: FIFO flag reaches the top bits
  p_fifo_bits_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ident_o[7:6] == {2{fifo_on}});

endmodule

// File: tb/uart_irq_ident_tb.sv
module uart_irq_ident_tb;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fifo_on = 0, ien_line = 0, ien_rx = 0, ien_tx = 0, ien_modem = 0;
  logic [3:0] line_err = '0, modem_delta = '0;
  logic rx_avail = 0, rx_timeout = 0, thr_empty = 0;
  logic rd_ident = 0, rd_line = 0, rd_modem = 0;
  logic irq_o;
  logic [7:0] ident_o;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #10 clk = ~clk;

  uart_irq_ident u_dut (
    .clk(clk), .rst_n(rst_n), .fifo_on(fifo_on), .ien_line(ien_line),
    .ien_rx(ien_rx), .ien_tx(ien_tx), .ien_modem(ien_modem),
    .line_err(line_err), .rx_avail(rx_avail), .rx_timeout(rx_timeout),
    .thr_empty(thr_empty), .modem_delta(modem_delta), .rd_ident(rd_ident),
    .rd_line(rd_line), .rd_modem(rd_modem), .irq_o(irq_o), .ident_o(ident_o));

  // Driver: push the expectation for the current cycle, then move on.
  task automatic step(input logic [7:0] exp, input string tag);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    @(posedge clk);
    #1;
  endtask

  // Monitor: compare in the middle of the cycle.
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      logic [7:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (ident_o !== e || irq_o !== ~e[0]) begin
        errors++;
        $display("FAIL %s ident=%02h irq=%0b expected ident=%02h irq=%0b",
                 t, ident_o, irq_o, e, ~e[0]);
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 5000) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    step(8'h01, "R1 reset");
    fifo_on = 1;          step(8'hC1, "R2 fifo bits");
    // transmit empty cause
    thr_empty = 1;        step(8'hC1, "R12 arming hidden");
                          step(8'hC1, "R12 armed but disabled");
    ien_tx = 1;           step(8'hC2, "R7 shown on enable");
    rd_ident = 1;         step(8'hC2, "R8 read cycle");
    rd_ident = 0;         step(8'hC1, "R8 acked");
    ien_tx = 0;           step(8'hC1, "R9 disabled");
    ien_tx = 1;           step(8'hC1, "R9 enable rise");
                          step(8'hC2, "R9 rearmed by enable");
    thr_empty = 0;        step(8'hC2, "R9 load cycle");
                          step(8'hC1, "R9 disarmed by load");
    thr_empty = 1;        step(8'hC1, "R7 empty rise");
                          step(8'hC2, "R7 rearmed by empty");
    // modem beneath transmit
    ien_modem = 1; modem_delta = 4'b0100; step(8'hC2, "R11 modem event");
    modem_delta = 0;      step(8'hC2, "R11 tx over modem");
    rd_ident = 1;         step(8'hC2, "R8 read tx");
    rd_ident = 0;         step(8'hC0, "R10 modem exposed");
    rd_ident = 1;         step(8'hC0, "R8 read modem code");
    rd_ident = 0;         step(8'hC0, "R8 read other code no effect");
    rd_modem = 1;         step(8'hC0, "R10 modem read");
    rd_modem = 0;         step(8'hC1, "R10 modem cleared");
    modem_delta = 4'b0001; rd_modem = 1; step(8'hC1, "R10 event with read");
    modem_delta = 0; rd_modem = 0;       step(8'hC0, "R10 event wins");
    rd_modem = 1;         step(8'hC0, "R10 read");
    rd_modem = 0;         step(8'hC1, "R10 cleared");
    for (int b = 0; b < 4; b++) begin
      modem_delta = 4'b0001 << b; step(8'hC1, "R10 delta bit");
      modem_delta = 0;            step(8'hC0, "R10 delta bit latched");
      rd_modem = 1;               step(8'hC0, "R10 delta read");
      rd_modem = 0;               step(8'hC1, "R10 delta cleared");
    end
    // receive
    ien_rx = 1; rx_avail = 1;  step(8'hC4, "R5 data ready");
    rx_timeout = 1;            step(8'hC4, "R6 data over timeout");
    rx_avail = 0;              step(8'hCC, "R6 timeout");
    fifo_on = 0;               step(8'h01, "R6 timeout ignored without fifo");
    fifo_on = 1; rx_timeout = 0; step(8'hC1, "R6 timeout gone");
    // line errors
    ien_line = 0; line_err = 4'b0001; step(8'hC1, "R12 line event hidden");
    line_err = 0;              step(8'hC1, "R12 line hidden");
    ien_line = 1;              step(8'hC6, "R12 line retained");
    rx_avail = 1; ien_tx = 0; thr_empty = 0; step(8'hC6, "R11 line over rx");
    rd_line = 1;               step(8'hC6, "R4 read cycle");
    rd_line = 0;               step(8'hC4, "R4 line cleared rx shown");
    rx_avail = 0;              step(8'hC1, "R5 data gone");
    line_err = 4'b1000; rd_line = 1; step(8'hC1, "R4 event with read");
    line_err = 0; rd_line = 0; step(8'hC6, "R4 event wins");
    rd_line = 1;               step(8'hC6, "R4 read");
    rd_line = 0;               step(8'hC1, "R4 cleared");
    for (int b = 0; b < 4; b++) begin
      line_err = 4'b0001 << b; step(8'hC1, "R3 error bit");
      line_err = 0;            step(8'hC6, "R3 error latched");
      rd_line = 1;             step(8'hC6, "R3 error read");
      rd_line = 0;             step(8'hC1, "R3 error cleared");
    end
    // line over modem and transmit together
    ien_tx = 1; thr_empty = 1; modem_delta = 4'b1000; line_err = 4'b0010;
                               step(8'hC1, "R11 stack events");
    modem_delta = 0; line_err = 0; step(8'hC6, "R11 line top");
    rd_line = 1;               step(8'hC6, "R11 read line");
    rd_line = 0;               step(8'hC2, "R11 tx next");
    fifo_on = 0;               step(8'h02, "R2 fifo off bits");
    while (exp_q.size() > 0) @(posedge clk);
    #1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule